// File: doc/BRIEF.md
# Counted Shift and Rotate Unit

This block shifts or rotates two 18-bit one's complement words: an accumulator word and an in-out word. A start strobe brings in a 13-bit variation field. The field chooses the direction, the kind of move (arithmetic shift or cyclic rotate) and which word takes part: the accumulator, the in-out word, or both joined into one 36-bit value with the in-out word as the low half. The number of steps is not a binary number. It is the count of set bits in a 9-bit mask, so a one-bit mask gives one step wherever its bit is placed.

The unit moves the data one position per clock. When the requested number of positions is done, it raises a one-cycle done pulse. While it is idle, both words can be loaded in parallel from the load inputs. A start strobe that comes while the unit is busy is dropped, and so is a load request.

In the bit numbering below, vector bit 17 of each word is its sign and vector bit 0 is its least significant bit. In the joined pair, accumulator bit 0 sits directly above in-out bit 17.

Top module: `shift_rotate_unit`

## Requirements
- R1: While `rst_n` is low at a clock edge, `ac`, `io`, `busy` and `done` are all cleared to zero.
- R2: With `busy` low, a high `load` at a clock edge copies `load_ac` to `ac` and `load_io` to `io` at that edge. While `busy` is high, `load` is ignored.
- R3: The step count N is the number of ones in `field[8:0]`. Suppose a start is accepted at edge k and N is greater than 0. Then the words change at edges k+1 to k+N, one position per edge. `busy` is high from edge k until edge k+N. `done` is high for exactly the one cycle that follows edge k+N, and the final values are on `ac` and `io` during that cycle.
- R4: When N is 0, `done` is high for the one cycle that follows edge k, `busy` stays low and neither word changes.
- R5: `field[10:9]` selects the operand. 01 selects `ac` alone and leaves `io` unchanged. 10 selects `io` alone and leaves `ac` unchanged. 11 selects the joined 36-bit value {ac, io}. 00 changes neither word but still takes N cycles.
- R6: `field[12]` selects the direction: 1 means right, toward bit 0, and 0 means left. `field[11]` = 0 selects a rotate, in which the bit that leaves one end enters the other end.
- R7: `field[11]` = 1 with `field[12]` = 1 is an arithmetic right shift. The sign bit stays in place and is also copied into the next bit down. The bit that leaves bit 0 is lost. For the joined pair, the accumulator sign fills the vacated bits and accumulator bit 0 moves into in-out bit 17.
- R8: `field[11]` = 1 with `field[12]` = 0 is an arithmetic left shift. The sign bit stays in place, the bit just below the sign is lost, and the sign value enters bit 0. For the joined pair, in-out bit 17 moves into accumulator bit 0 and the accumulator sign enters in-out bit 0.
- R9: A joined rotate treats all 36 bits as one ring. Accumulator bit 17 and in-out bit 0 are neighbours across the wrap.
- R10: A start strobe that arrives while `busy` is high is ignored. The running operation ends at the same time and with the same result as it would without the strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Start strobe; accepted only while idle |
| field | input | 13 | Variation field: [12] direction, [11] arithmetic, [10:9] operand select, [8:0] step mask |
| load | input | 1 | Parallel load request; accepted only while idle |
| load_ac | input | 18 | Value loaded into the accumulator word |
| load_io | input | 18 | Value loaded into the in-out word |
| busy | output | 1 | High while steps remain |
| done | output | 1 | One-cycle pulse when the operation is complete |
| ac | output | 18 | Accumulator word |
| io | output | 18 | In-out word |

## Verification
The directed cases test the count rule with the same single-step count placed at the top and at the bottom of the mask, and with a full and an empty mask. They also run every operand selection, including the empty one. Negative words, among them minus zero, are shifted both ways: this separates a sign-preserving shift from a plain logical shift, and shows whether the sign is written into the low bit on a left shift. Rotates and arithmetic shifts on the joined pair show whether bits cross correctly between the two halves at the seam and at the wrap. Random fields and words are run next, some with a start and a load injected in the middle of an operation, to confirm that neither strobe changes the result or the timing.

// File: rtl/sru_pkg.sv
// Package: shared operand selector and decoded-operation types for the
// shift/rotate unit. Assumes the select code sits in a 2-bit field.
package sru_pkg;

    typedef enum logic [1:0] {
        SEL_NONE = 2'b00,
        SEL_AC   = 2'b01,
        SEL_IO   = 2'b10,
        SEL_BOTH = 2'b11
    } sel_e;

    typedef struct packed {
        logic right;   // 1 = move toward bit 0
        logic arith;   // 1 = sign-keeping shift, 0 = rotate
        sel_e sel;     // operand selection
    } op_t;

endpackage

// File: rtl/sru_decode.sv
// Module: splits the variation field into direction, kind and operand select,
// and counts the ones in the step mask.
// Assumes field layout {dir, arith, sel[1:0], mask[MASK_W-1:0]}.
module sru_decode #(
    parameter int MASK_W = 9,
    localparam int FIELD_W = MASK_W + 4,
    localparam int CNT_W   = $clog2(MASK_W + 1)
) (
    input  logic [FIELD_W-1:0] field,
    output sru_pkg::op_t       op,
    output logic [CNT_W-1:0]   steps
);
    import sru_pkg::*;

    // Field split into the decoded operation.
    always_comb begin
        op.right = field[MASK_W+3];
        op.arith = field[MASK_W+2];
        op.sel   = sel_e'(field[MASK_W+1:MASK_W]);
    end

    // Population count of the step mask.
    always_comb begin
        steps = '0;
        for (int b = 0; b < MASK_W; b++) begin
            steps = steps + CNT_W'(field[b]);
        end
    end

endmodule

// File: rtl/sru_step.sv
// Module: one-position move of a W-bit one's complement word: rotate left or
// right, or sign-keeping arithmetic shift left or right.
// Assumes W >= 3 and that bit W-1 is the sign.
module sru_step #(
    parameter int W = 18
) (
    input  logic [W-1:0] x,
    input  logic         right,
    input  logic         arith,
    output logic [W-1:0] y
);

    // Select the one-step result for the requested kind and direction.
    always_comb begin
        unique case ({arith, right})
            2'b00:   y = {x[W-2:0], x[W-1]};
            2'b01:   y = {x[0], x[W-1:1]};
            2'b10:   y = {x[W-1], x[W-3:0], x[W-1]};
            default: y = {x[W-1], x[W-1], x[W-2:1]};
        endcase
    end

endmodule

// File: rtl/sru_ctrl.sv
// Module: step sequencer. Accepts a start while idle, loads the remaining
// count, runs one step per clock, and pulses done after the last step
// (or at once for a zero count). Assumes steps <= 2**CNT_W - 1.
module sru_ctrl #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] steps,
    output logic             accept,
    output logic             busy,
    output logic             done
);

    logic [CNT_W-1:0] remain;

    // A start counts only while idle.
    assign accept = start && !busy;

    // Countdown of the remaining steps, with busy and done flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            done   <= 1'b0;
            remain <= '0;
        end else begin
            done <= 1'b0;
            if (!busy) begin
                if (start) begin
                    if (steps == '0) begin
                        done <= 1'b1;
                    end else begin
                        busy   <= 1'b1;
                        remain <= steps;
                    end
                end
            end else begin
                remain <= remain - CNT_W'(1);
                if (remain == CNT_W'(1)) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end

    // R3: done is never high while steps remain.
    a_r3_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R3: the count falls by one each busy cycle and busy holds until the end.
    a_r3_countdown: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && remain > CNT_W'(1)) |=> (busy && remain == $past(remain) - CNT_W'(1)));

    // R4: an accepted zero count gives done at once without going busy.
    a_r4_zero_count: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && steps == '0) |=> (done && !busy));

    // R10: a start while busy does not reload the count.
    a_r10_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> (remain == $past(remain) - CNT_W'(1)));

endmodule

// File: rtl/shift_rotate_unit.sv
// Module: counted shift/rotate unit for an accumulator word and an in-out
// word, alone or joined as {ac, io}. Holds both words, latches the decoded
// operation on an accepted start and applies one step per clock.
// Assumes WORD_W >= 3; vector bit WORD_W-1 is the sign of each word.
module shift_rotate_unit #(
    parameter int WORD_W = 18,
    parameter int MASK_W = 9,
    localparam int FIELD_W = MASK_W + 4,
    localparam int CNT_W   = $clog2(MASK_W + 1),
    localparam int PAIR_W  = 2 * WORD_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [FIELD_W-1:0] field,
    input  logic               load,
    input  logic [WORD_W-1:0]  load_ac,
    input  logic [WORD_W-1:0]  load_io,
    output logic               busy,
    output logic               done,
    output logic [WORD_W-1:0]  ac,
    output logic [WORD_W-1:0]  io
);
    import sru_pkg::*;

    op_t              op_dec;
    op_t              op_q;
    logic [CNT_W-1:0] steps;
    logic             accept;
    logic [WORD_W-1:0] ac_next;
    logic [WORD_W-1:0] io_next;
    logic [PAIR_W-1:0] pair_next;

    sru_decode #(.MASK_W(MASK_W)) u_decode (
        .field (field),
        .op    (op_dec),
        .steps (steps)
    );

    sru_ctrl #(.CNT_W(CNT_W)) u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .steps  (steps),
        .accept (accept),
        .busy   (busy),
        .done   (done)
    );

    sru_step #(.W(WORD_W)) u_step_ac (
        .x (ac), .right (op_q.right), .arith (op_q.arith), .y (ac_next)
    );

    sru_step #(.W(WORD_W)) u_step_io (
        .x (io), .right (op_q.right), .arith (op_q.arith), .y (io_next)
    );

    sru_step #(.W(PAIR_W)) u_step_pair (
        .x ({ac, io}), .right (op_q.right), .arith (op_q.arith), .y (pair_next)
    );

    // Latch the decoded operation when a start is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q <= '0;
        end else if (accept) begin
            op_q <= op_dec;
        end
    end

    // Word registers: one step per busy cycle, parallel load while idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ac <= '0;
            io <= '0;
        end else if (busy) begin
            unique case (op_q.sel)
                SEL_AC:   ac <= ac_next;
                SEL_IO:   io <= io_next;
                SEL_BOTH: {ac, io} <= pair_next;
                default:  ;
            endcase
        end else if (load) begin
            ac <= load_ac;
            io <= load_io;
        end
    end

    // R2: with no load and no step, both words hold.
    a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !load) |=> ($stable(ac) && $stable(io)));

    // R5: an accumulator-only operation leaves the in-out word alone.
    a_r5_io_untouched: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && op_q.sel == SEL_AC) |=> $stable(io));

    // R7: an arithmetic move on the accumulator keeps its sign.
    a_r7_sign_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && op_q.arith && op_q.sel == SEL_AC) |=> (ac[WORD_W-1] == $past(ac[WORD_W-1])));

    // R9: a joined rotate neither gains nor loses a one.
    a_r9_ring_ones: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !op_q.arith && op_q.sel == SEL_BOTH) |=>
            ($countones({ac, io}) == $countones($past({ac, io}))));

endmodule

// File: tb/test_shift_rotate_unit.sv
// Bench: directed corner cases plus seeded random operations, checked
// against a shift-operator reference model. Clock 125 MHz (8 time units).
module test_shift_rotate_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        load = 1'b0;
    logic [12:0] field = '0;
    logic [17:0] load_ac = '0;
    logic [17:0] load_io = '0;
    logic        busy;
    logic        done;
    logic [17:0] ac;
    logic [17:0] io;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    shift_rotate_unit i_shift_rotate_unit (
        .clk (clk), .rst_n (rst_n), .start (start), .field (field),
        .load (load), .load_ac (load_ac), .load_io (load_io),
        .busy (busy), .done (done), .ac (ac), .io (io)
    );

    always #4 clk = ~clk;

    task automatic check(input string req, input string what,
                         input longint unsigned act, input longint unsigned exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic int popc(input logic [8:0] m);
        int n = 0;
        for (int b = 0; b < 9; b++) n += int'(m[b]);
        return n;
    endfunction

    // Reference: n-position move of a w-bit word built from whole-word shifts.
    function automatic longint unsigned xf(input longint unsigned x, input int w,
                                           input int n, input bit right, input bit arith);
        longint unsigned mask = (64'd1 << w) - 64'd1;
        longint unsigned s = (x >> (w - 1)) & 64'd1;
        longint unsigned fill;
        if (n == 0) return x;
        if (!arith) begin
            if (right) return ((x >> n) | (x << (w - n))) & mask;
            return ((x << n) | (x >> (w - n))) & mask;
        end
        if (right) begin
            fill = (s != 0) ? (mask & ~(mask >> n)) : 64'd0;
            return (x >> n) | fill;
        end
        fill = (s != 0) ? ((64'd1 << n) - 64'd1) : 64'd0;
        return (((x << n) | fill) & (mask >> 1)) | (s << (w - 1));
    endfunction

    function automatic logic [35:0] model(input logic [17:0] a, input logic [17:0] i,
                                          input logic [12:0] f);
        int  n = popc(f[8:0]);
        bit  r = f[12];
        bit  ar = f[11];
        logic [35:0] p;
        case (f[10:9])
            2'b01:   a = 18'(xf(64'(a), 18, n, r, ar));
            2'b10:   i = 18'(xf(64'(i), 18, n, r, ar));
            2'b11: begin
                p = 36'(xf(64'({a, i}), 36, n, r, ar));
                a = p[35:18];
                i = p[17:0];
            end
            default: ;
        endcase
        return {a, i};
    endfunction

    task automatic load_regs(input logic [17:0] a, input logic [17:0] i);
        @(negedge clk);
        load = 1'b1; load_ac = a; load_io = i;
        @(negedge clk);
        load = 1'b0;
        check("R2", "loaded ac", 64'(ac), 64'(a));
        check("R2", "loaded io", 64'(io), 64'(i));
    endtask

    // Runs one operation; with disturb set, injects a start and a load mid-run.
    task automatic run_op(input logic [12:0] f, input bit disturb, input string req);
        logic [35:0] exp = model(ac, io, f);
        int n = popc(f[8:0]);
        int bad = 0;
        @(negedge clk);
        start = 1'b1; field = f;
        @(negedge clk);
        start = 1'b0;
        for (int s = 0; s < n; s++) begin
            if (done !== 1'b0 || busy !== 1'b1) bad++;
            if (disturb && s == 1) begin
                start = 1'b1; field = ~f; load = 1'b1;
                load_ac = 18'h2AAAA; load_io = 18'h15555;
            end else if (disturb && s == 2) begin
                start = 1'b0; load = 1'b0;
            end
            @(negedge clk);
        end
        check(req, "busy high and done low during steps", 64'(bad), 64'd0);
        check(req, "done at end", 64'(done), 64'd1);
        check(req, "busy at end", 64'(busy), 64'd0);
        check(req, "ac result", 64'(ac), 64'(exp[35:18]));
        check(req, "io result", 64'(io), 64'(exp[17:0]));
        @(negedge clk);
        check(req, "done is one cycle", 64'(done), 64'd0);
        if (disturb) begin
            bad = 0;
            for (int s = 0; s < 10; s++) begin
                if (done !== 1'b0 || busy !== 1'b0) bad++;
                @(negedge clk);
            end
            check("R10", "ignored start never runs", 64'(bad), 64'd0);
            check("R2", "ignored load left ac", 64'(ac), 64'(exp[35:18]));
            check("R2", "ignored load left io", 64'(io), 64'(exp[17:0]));
        end
    endtask

    initial begin
        #(8 * 150000);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1F2E3D4C));
        repeat (3) @(negedge clk);
        check("R1", "ac in reset", 64'(ac), 64'd0);
        check("R1", "io in reset", 64'(io), 64'd0);
        check("R1", "busy in reset", 64'(busy), 64'd0);
        check("R1", "done in reset", 64'(done), 64'd0);
        rst_n = 1'b1;

        load_regs(18'h20001, 18'h3FFFE);
        run_op({1'b1, 1'b0, 2'b01, 9'h001}, 1'b0, "R6");   // ac rotate right, low mask bit
        run_op({1'b0, 1'b0, 2'b01, 9'h100}, 1'b0, "R3");   // ac rotate left, high mask bit
        load_regs(18'h24000, 18'h0F0F0);
        run_op({1'b1, 1'b1, 2'b01, 9'h1FF}, 1'b0, "R7");   // negative ac, nine right shifts
        run_op({1'b0, 1'b1, 2'b11, 9'h000}, 1'b0, "R4");   // zero count
        run_op({1'b1, 1'b0, 2'b00, 9'h01F}, 1'b0, "R5");   // nothing selected
        load_regs(18'h13579, 18'h28001);
        run_op({1'b0, 1'b1, 2'b10, 9'h007}, 1'b0, "R8");   // negative io, left shift
        run_op({1'b1, 1'b1, 2'b10, 9'h003}, 1'b0, "R7");
        load_regs(18'h20003, 18'h00005);
        run_op({1'b0, 1'b0, 2'b11, 9'h1FF}, 1'b0, "R9");   // joined ring left
        run_op({1'b1, 1'b0, 2'b11, 9'h055}, 1'b0, "R9");   // joined ring right
        load_regs(18'h30001, 18'h00000);
        run_op({1'b1, 1'b1, 2'b11, 9'h00F}, 1'b0, "R7");   // joined sign fill across seam
        load_regs(18'h20000, 18'h20001);
        run_op({1'b0, 1'b1, 2'b11, 9'h003}, 1'b0, "R8");   // joined left, io top into ac
        load_regs(18'h3FFFF, 18'h3FFFF);
        run_op({1'b0, 1'b1, 2'b01, 9'h0FF}, 1'b0, "R8");   // minus zero stays minus zero
        load_regs(18'h1234A, 18'h2BCDE);
        run_op({1'b1, 1'b1, 2'b11, 9'h1F0}, 1'b1, "R10");  // disturbed run

        for (int k = 0; k < 250; k++) begin
            logic [12:0] f = 13'($urandom);
            if ($urandom_range(0, 2) == 0) load_regs(18'($urandom), 18'($urandom));
            run_op(f, (popc(f[8:0]) >= 4) && ($urandom_range(0, 3) == 0), "R3 random");
        end

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule